// File: doc/BRIEF.md
# VGA 640x480 Timing Generator

This block produces the raster timing for a 640x480 display: active-low horizontal and vertical sync, a flag that marks the visible region, and the current column and row counts. It runs on a system clock at twice the pixel rate. An internal toggle flop turns that clock into a pixel-rate enable, so the coordinates move on every second system clock.

A one-clock `pixel_tick` pulse marks each coordinate update. Downstream colour logic uses it to stay in step with the counts. That logic must drive black whenever `video_active` is low. Each line is 800 pixel periods: the visible span, a short blank, the sync pulse, then a longer blank. Each frame is 525 lines built the same way. Every span length is a parameter, and the defaults give the standard 640x480 mode.

Top module: `vga_timing_gen`

## Requirements
- R1: While `rst` is sampled high at a rising clock edge, the following clock shows `px_x`=0, `px_y`=0, `hsync_n`=1, `vsync_n`=1, `video_active`=1 and `pixel_tick`=0.
- R2: After reset is released, `pixel_tick` is high on the first clock and then alternates low and high on every clock. `px_x`, `px_y` and the three timing outputs change only at the edges that raise `pixel_tick`.
- R3: `px_x` rises by one at each update and goes from H_TOTAL-1 (799 by default) back to 0.
- R4: `px_y` rises by one at the update where `px_x` goes from H_TOTAL-1 to 0, and otherwise holds. It goes from V_TOTAL-1 (524 by default) back to 0.
- R5: `hsync_n` is 0 exactly while `px_x` is in H_VISIBLE+H_FRONT through H_VISIBLE+H_FRONT+H_SYNC-1 (656..751 by default), and 1 otherwise.
- R6: `vsync_n` is 0 exactly while `px_y` is in V_VISIBLE+V_FRONT through V_VISIBLE+V_FRONT+V_SYNC-1 (490..491 by default), and 1 otherwise.
- R7: `video_active` is 1 exactly when `px_x` < H_VISIBLE and `px_y` < V_VISIBLE.
- R8: A reset asserted mid-frame, on either phase of the pixel enable, returns every output to the R1 state. Counting then resumes from 0,0 as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at twice the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| px_x | output | XW (10 by default) | Current column count |
| px_y | output | YW (10 by default) | Current row count |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| video_active | output | 1 | High inside the visible region |
| pixel_tick | output | 1 | One-clock pulse at each coordinate update |

## Verification
The assertions need only a clean synchronous reset, because the block has no data inputs. Every property is gated off while `rst` is high, except the reset-state property, which depends on the reset alone. The bench builds the design with reduced span lengths so that several complete frames fit within the run. It compares every output on every clock with an arithmetic model of the counts. It then asserts reset mid-frame on both enable phases, holds it for at least one edge, and releases it only at a falling edge.

// File: rtl/vga_timing_pkg.sv
package vga_timing_pkg;

    // Decoded per-pixel control bits, registered together.
    typedef struct packed {
        logic hsync_n;
        logic vsync_n;
        logic active;
    } vga_ctl_t;

    // Value shown while in reset: syncs idle, origin is visible.
    localparam vga_ctl_t CTL_RESET = '{hsync_n: 1'b1, vsync_n: 1'b1, active: 1'b1};

    // True when v lies in [lo, lo+len).
    function automatic logic in_span(input int unsigned v,
                                     input int unsigned lo,
                                     input int unsigned len);
        return (v >= lo) && (v < lo + len);
    endfunction

    // Counter width for a count of 0..total-1.
    function automatic int unsigned cnt_width(input int unsigned total);
        return (total < 2) ? 1 : $clog2(total);
    endfunction

endpackage

// File: rtl/vga_pixel_enable.sv
module vga_pixel_enable (
    input  logic clk,
    input  logic rst,
    output logic pix_en,
    output logic tick
);
    logic phase;

    // Enable is high while the toggle is clear, so the first edge after reset updates.
    assign pix_en = ~phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 1'b0;
            tick  <= 1'b0;
        end else begin
            phase <= ~phase;
            tick  <= pix_en;
        end
    end

    // R2: the tick pulse alternates every clock once out of reset
    assert_tick_falls_R2: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
    assert_tick_rises_R2: assert property (@(posedge clk) disable iff (rst) !tick |=> tick);

endmodule

// File: rtl/vga_axis_counter.sv
module vga_axis_counter #(
    parameter int unsigned TOTAL = 800,
    parameter int unsigned W     = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_next,
    output logic         at_last
);
    localparam logic [W-1:0] LAST = W'(TOTAL - 1);

    assign at_last = (cnt == LAST);

    always_comb begin
        cnt_next = cnt;
        if (step) begin
            cnt_next = at_last ? '0 : cnt + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_next;
    end

    // R3: the count never leaves 0..TOTAL-1
    assert_count_range_R3: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);
    // R3: a step at the last value returns to zero
    assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (step && at_last) |=> (cnt == '0));
    // R2: without a step the count holds
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cnt));

endmodule

// File: rtl/vga_sync_decode.sv
module vga_sync_decode
    import vga_timing_pkg::*;
#(
    parameter int unsigned H_VISIBLE = 640,
    parameter int unsigned H_FRONT   = 16,
    parameter int unsigned H_SYNC    = 96,
    parameter int unsigned V_VISIBLE = 480,
    parameter int unsigned V_FRONT   = 10,
    parameter int unsigned V_SYNC    = 2,
    parameter int unsigned XW        = 10,
    parameter int unsigned YW        = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [XW-1:0] x_next,
    input  logic [YW-1:0] y_next,
    output vga_ctl_t      ctl
);
    localparam int unsigned HS_START = H_VISIBLE + H_FRONT;
    localparam int unsigned VS_START = V_VISIBLE + V_FRONT;

    vga_ctl_t ctl_next;

    // Decode from the coordinates about to be registered, so outputs line up with them.
    always_comb begin
        ctl_next.hsync_n = ~in_span(32'(x_next), HS_START, H_SYNC);
        ctl_next.vsync_n = ~in_span(32'(y_next), VS_START, V_SYNC);
        ctl_next.active  = (32'(x_next) < H_VISIBLE) && (32'(y_next) < V_VISIBLE);
    end

    always_ff @(posedge clk) begin
        if (rst)     ctl <= CTL_RESET;
        else if (en) ctl <= ctl_next;
    end

    // R2: decoded outputs move only on an enable
    assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(ctl));

endmodule

// File: rtl/vga_timing_gen.sv
module vga_timing_gen
    import vga_timing_pkg::*;
#(
    parameter int unsigned H_VISIBLE = 640,
    parameter int unsigned H_FRONT   = 16,
    parameter int unsigned H_SYNC    = 96,
    parameter int unsigned H_BACK    = 48,
    parameter int unsigned V_VISIBLE = 480,
    parameter int unsigned V_FRONT   = 10,
    parameter int unsigned V_SYNC    = 2,
    parameter int unsigned V_BACK    = 33,
    localparam int unsigned H_TOTAL  = H_VISIBLE + H_FRONT + H_SYNC + H_BACK,
    localparam int unsigned V_TOTAL  = V_VISIBLE + V_FRONT + V_SYNC + V_BACK,
    localparam int unsigned XW       = cnt_width(H_TOTAL),
    localparam int unsigned YW       = cnt_width(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [XW-1:0] px_x,
    output logic [YW-1:0] px_y,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          video_active,
    output logic          pixel_tick
);
    localparam int unsigned HS_START = H_VISIBLE + H_FRONT;
    localparam int unsigned VS_START = V_VISIBLE + V_FRONT;

    logic          pix_en;
    logic          h_last;
    logic          v_last;
    logic          v_step;
    logic [XW-1:0] x_next;
    logic [YW-1:0] y_next;
    vga_ctl_t      ctl;

    vga_pixel_enable u_pix_en (
        .clk    (clk),
        .rst    (rst),
        .pix_en (pix_en),
        .tick   (pixel_tick)
    );

    vga_axis_counter #(.TOTAL(H_TOTAL), .W(XW)) u_hcnt (
        .clk      (clk),
        .rst      (rst),
        .step     (pix_en),
        .cnt      (px_x),
        .cnt_next (x_next),
        .at_last  (h_last)
    );

    assign v_step = pix_en & h_last;

    vga_axis_counter #(.TOTAL(V_TOTAL), .W(YW)) u_vcnt (
        .clk      (clk),
        .rst      (rst),
        .step     (v_step),
        .cnt      (px_y),
        .cnt_next (y_next),
        .at_last  (v_last)
    );

    vga_sync_decode #(
        .H_VISIBLE (H_VISIBLE), .H_FRONT (H_FRONT), .H_SYNC (H_SYNC),
        .V_VISIBLE (V_VISIBLE), .V_FRONT (V_FRONT), .V_SYNC (V_SYNC),
        .XW (XW), .YW (YW)
    ) u_decode (
        .clk    (clk),
        .rst    (rst),
        .en     (pix_en),
        .x_next (x_next),
        .y_next (y_next),
        .ctl    (ctl)
    );

    assign hsync_n      = ctl.hsync_n;
    assign vsync_n      = ctl.vsync_n;
    assign video_active = ctl.active;

    // R1 / R8: a sampled reset always leaves the idle state on the next clock
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (px_x == '0 && px_y == '0 && hsync_n && vsync_n && video_active && !pixel_tick));

    // R2: no coordinate change in the clock after an update
    assert_coord_stable_R2: assert property (@(posedge clk) disable iff (rst)
        pixel_tick |=> ($stable(px_x) && $stable(px_y)));

    // R4: row advances exactly at the end of a line
    assert_row_step_R4: assert property (@(posedge clk) disable iff (rst)
        (pix_en && h_last) |=>
            (px_y == (($past(px_y) == YW'(V_TOTAL - 1)) ? '0 : $past(px_y) + YW'(1))));
    assert_row_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(pix_en && h_last) |=> $stable(px_y));

    // R5: registered horizontal sync agrees with the registered column
    assert_hsync_window_R5: assert property (@(posedge clk) disable iff (rst)
        hsync_n == !in_span(32'(px_x), HS_START, H_SYNC));

    // R6: registered vertical sync agrees with the registered row
    assert_vsync_window_R6: assert property (@(posedge clk) disable iff (rst)
        vsync_n == !in_span(32'(px_y), VS_START, V_SYNC));

    // R7: visible flag agrees with both registered counts
    assert_active_region_R7: assert property (@(posedge clk) disable iff (rst)
        video_active == ((32'(px_x) < H_VISIBLE) && (32'(px_y) < V_VISIBLE)));

    // Row counter wrap is tied to the last line of a frame.
    assert_frame_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (v_step && v_last) |=> (px_y == '0));

endmodule

// File: tb/vga_timing_gen_tb.sv
module vga_timing_gen_tb;

    localparam int HV = 8, HF = 2, HS = 3, HB = 2;
    localparam int VV = 6, VF = 1, VS = 2, VB = 1;
    localparam int HT = HV + HF + HS + HB;
    localparam int VT = VV + VF + VS + VB;
    localparam int XW = $clog2(HT);
    localparam int YW = $clog2(VT);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [XW-1:0] px_x;
    logic [YW-1:0] px_y;
    logic          hsync_n, vsync_n, video_active, pixel_tick;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // model state
    int ex, ey;
    bit mph;
    bit etick;

    always #4 clk = ~clk;

    vga_timing_gen #(
        .H_VISIBLE(HV), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
        .V_VISIBLE(VV), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB)
    ) u_dut (
        .clk(clk), .rst(rst), .px_x(px_x), .px_y(px_y),
        .hsync_n(hsync_n), .vsync_n(vsync_n),
        .video_active(video_active), .pixel_tick(pixel_tick)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_reset_state(input string req);
        check(req, "px_x", px_x, 0);
        check(req, "px_y", px_y, 0);
        check(req, "hsync_n", hsync_n, 1);
        check(req, "vsync_n", vsync_n, 1);
        check(req, "video_active", video_active, 1);
        check(req, "pixel_tick", pixel_tick, 0);
    endtask

    // Advance the model by one system clock and compare at the falling edge.
    task automatic step_and_compare();
        @(posedge clk);
        etick = !mph;
        if (!mph) begin
            if (ex == HT - 1) begin
                ex = 0;
                ey = (ey == VT - 1) ? 0 : ey + 1;
            end else begin
                ex = ex + 1;
            end
        end
        mph = !mph;
        @(negedge clk);
        check("R2", "pixel_tick", pixel_tick, etick);
        check("R3", "px_x", px_x, ex);
        check("R4", "px_y", px_y, ey);
        check("R5", "hsync_n", hsync_n, !(ex >= HV + HF && ex < HV + HF + HS));
        check("R6", "vsync_n", vsync_n, !(ey >= VV + VF && ey < VV + VF + VS));
        check("R7", "video_active", video_active, (ex < HV && ey < VV));
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst = 1'b0;
        ex = 0; ey = 0; mph = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state("R1");
        release_reset();
        // three full frames: every column, row and window edge, plus frame wraps
        for (int i = 0; i < 3 * 2 * HT * VT; i++) step_and_compare();

        // R8: reset mid-frame on the phase right after an update
        for (int i = 0; i < 37; i++) step_and_compare();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_reset_state("R8");
        release_reset();
        for (int i = 0; i < 2 * HT * VT; i++) step_and_compare();

        // R8: reset mid-frame on the other phase, held for two edges
        for (int i = 0; i < 52; i++) step_and_compare();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_reset_state("R8");
        release_reset();
        for (int i = 0; i < 2 * HT * VT + 40; i++) step_and_compare();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule